// File: doc/BRIEF.md
# Write-Leveling Strobe Alignment Trainer

This block trains the launch delay of one byte lane's data strobe so that the strobe's rising edge lands on the memory clock edge at the DRAM. The DRAM is held in write-leveling mode by other logic. In that mode it samples the clock with each strobe edge and returns the sampled bit on its data lines. The trainer asks for a strobe burst and waits for the returned bit. It filters that bit over several bursts and then moves the delay tap one step toward the clock edge. It stops when the filtered sample turns from 0 to 1.

Every lane sits at its own trace distance from the controller, so each lane has its own trainer. A start pulse loads a seed tap and begins the loop. While the trainer is done, it reports the aligned tap and a fail flag. The fail flag is set when the tap reaches the end of its range before any transition is seen.

Top module: `wl_lane_trainer`

## Requirements
- R1: After reset, dqs_pulse_o, done_o and fail_o are 0 and tap_o is 0.
- R2: A start_i accepted while idle or done loads tap_o with tap_init_i. In the next cycle, dqs_pulse_o is high for exactly one cycle.
- R3: A tap step happens only after FILT_N (default 3) consecutive accepted samples carry the same value. A differing sample restarts the run at length 1.
- R4: A filtered sample of 0 increments tap_o by one. A filtered sample of 1 decrements it by one, unless R6 or R7 applies.
- R5: After each accepted sample that does not end training, the next strobe request rises exactly WAIT_CYC+1 (default 17) cycles after the cycle in which that sample was presented.
- R6: Training ends successfully when a filtered 1 follows a filtered 0. done_o rises with fail_o=0, and tap_o holds the tap at which the 1 was seen.
- R7: A filtered 1 at tap 0, or a filtered 0 at the top tap (2^TAP_W-1), ends training with done_o=1 and fail_o=1, and tap_o is left unchanged.
- R8: dq_valid_i is ignored unless the trainer is waiting for a response. A stray valid causes no tap change, no strobe request and no state change.
- R9: done_o and fail_o hold until the next start_i. In the cycle after start_i, both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin training (pulse) |
| tap_init_i | input | TAP_W | Seed delay tap loaded on start |
| dq_valid_i | input | 1 | Returned clock sample is valid |
| dq_i | input | 1 | Clock level sampled by the DRAM with the strobe |
| dqs_pulse_o | output | 1 | Request one strobe burst |
| tap_o | output | TAP_W | Strobe delay tap |
| done_o | output | 1 | Training finished |
| fail_o | output | 1 | Finished without finding the edge |

## Verification
The loop is driven by a bench model whose returned sample is 1 once the tap reaches a chosen edge position. Seeding below the edge tests the increment-only path. Seeding above the edge tests the path that decrements past the edge and then climbs back, which separates "first 1 after a 0" from "any 1". An edge at tap 0 and an edge beyond the top tap each reach one end of the range and must fail. An injected sample pattern such as 0,1,0,0,0 shows whether a broken run really restarts the filter. The gap between response and next strobe request, and stray valid pulses while idle or done, are checked cycle by cycle.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_RESP  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } wl_state_e;
endpackage

// File: rtl/wl_sample_filter.sv
module wl_sample_filter #(
  parameter int FILT_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic stable_o,
  output logic value_o
);
  localparam int CNT_W = $clog2(FILT_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_N);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             last_q;

  always_comb begin
    cnt_n = cnt_q;
    if (valid_i) begin
      if (cnt_q != '0 && bit_i == last_q)
        cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      else
        cnt_n = CNT_W'(1);
    end
  end

  assign stable_o = valid_i && (cnt_n >= CNT_MAX);
  assign value_o  = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
    end else if (valid_i) begin
      cnt_q  <= cnt_n;
      last_q <= bit_i;
    end
  end

  // the run must rebuild from 1 after a differing sample
  assert_run_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && cnt_q != '0 && bit_i != last_q) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/wl_tap_counter.sv
module wl_tap_counter #(
  parameter int TAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAP_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             at_min_o,
  output logic             at_max_o
);
  localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};

  logic [TAP_W-1:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tap_q <= '0;
    else if (load_i)               tap_q <= load_val_i;
    else if (inc_i && !at_max_o)   tap_q <= tap_q + 1'b1;
    else if (dec_i && !at_min_o)   tap_q <= tap_q - 1'b1;
  end

  assign tap_o    = tap_q;
  assign at_min_o = (tap_q == '0);
  assign at_max_o = (tap_q == TAP_TOP);

  assert_one_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && !dec_i && !at_max_o) |=> (tap_q != '0));
endmodule

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = $clog2(WAIT_CYC + 1);
  localparam logic [W-1:0] RELOAD = W'(WAIT_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  generate
    if (WAIT_CYC >= 2) begin : g_min_gap
      assert_gap_not_short_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !expired_o);
    end
  endgenerate
endmodule

// File: rtl/wl_lane_trainer.sv
module wl_lane_trainer
  import wl_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int WAIT_CYC = 16,
  parameter int FILT_N   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAP_W-1:0] tap_init_i,
  input  logic             dq_valid_i,
  input  logic             dq_i,
  output logic             dqs_pulse_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             done_o,
  output logic             fail_o
);
  wl_state_e state_q, state_n;
  logic      prev_q, prev_vld_q, fail_q;

  logic accept, stable, sval;
  logic at_min, at_max, expired;
  logic load, step_up, step_dn, fin_ok, fin_bad, finish;

  assign accept  = (state_q == ST_RESP) && dq_valid_i;
  assign load    = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;

  // 0 -> 1 across consecutive filtered decisions marks the clock edge
  assign fin_ok  = accept && stable && sval && prev_vld_q && !prev_q;
  assign fin_bad = accept && stable && !fin_ok &&
                   ((sval && at_min) || (!sval && at_max));
  assign finish  = fin_ok || fin_bad;
  assign step_up = accept && stable && !sval && !at_max;
  assign step_dn = accept && stable &&  sval && !fin_ok && !at_min;

  wl_sample_filter #(.FILT_N(FILT_N)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load | step_up | step_dn),
    .valid_i (accept),
    .bit_i   (dq_i),
    .stable_o(stable),
    .value_o (sval)
  );

  wl_tap_counter #(.TAP_W(TAP_W)) u_tap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(tap_init_i),
    .inc_i     (step_up),
    .dec_i     (step_dn),
    .tap_o     (tap_o),
    .at_min_o  (at_min),
    .at_max_o  (at_max)
  );

  wl_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && !finish),
    .run_i    (state_q == ST_WAIT),
    .expired_o(expired)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_n = ST_PULSE;
      ST_PULSE: state_n = ST_RESP;
      ST_RESP:  if (accept) state_n = finish ? ST_DONE : ST_WAIT;
      ST_WAIT:  if (expired) state_n = ST_PULSE;
      ST_DONE:  if (start_i) state_n = ST_PULSE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      prev_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      if (load) begin
        prev_vld_q <= 1'b0;
        fail_q     <= 1'b0;
      end else if (step_up || step_dn) begin
        prev_q     <= sval;
        prev_vld_q <= 1'b1;
      end
      if (fin_bad) fail_q <= 1'b1;
    end
  end

  assign dqs_pulse_o = (state_q == ST_PULSE);
  assign done_o      = (state_q == ST_DONE);
  assign fail_o      = fail_q;

  assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_pulse_o |=> !dqs_pulse_o);
  assert_tap_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dq_valid_i && !start_i) |=> $stable(tap_o));
  assert_fail_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(tap_o)));
endmodule

// File: tb/wl_lane_trainer_tb.sv
module wl_lane_trainer_tb_top;
  localparam int TAP_W    = 6;
  localparam int WAIT_CYC = 16;
  localparam int FILT_N   = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [TAP_W-1:0] tap_init_i = '0;
  logic             resp_valid = 1'b0, stray_valid = 1'b0;
  logic             resp_bit = 1'b0, stray_bit = 1'b0;
  logic             dqs_pulse_o, done_o, fail_o;
  logic [TAP_W-1:0] tap_o;

  int tests = 0, fails = 0;
  int cyc = 0;
  int edge_tap = 0;
  int pulse_cnt = 0, resp_cnt = 0;
  int tap_at_pulse [0:511];
  int pulse_cyc    [0:511];
  int resp_cyc     [0:511];
  logic ovr [0:15];
  int ovr_n = 0, ovr_i = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wl_lane_trainer #(.TAP_W(TAP_W), .WAIT_CYC(WAIT_CYC), .FILT_N(FILT_N)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tap_init_i (tap_init_i),
    .dq_valid_i (resp_valid | stray_valid),
    .dq_i       (stray_valid ? stray_bit : resp_bit),
    .dqs_pulse_o(dqs_pulse_o),
    .tap_o      (tap_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // DRAM model: returned sample is 1 once tap reaches edge_tap
  initial begin
    forever begin
      @(negedge clk);
      if (dqs_pulse_o) begin
        tap_at_pulse[pulse_cnt] = int'(tap_o);
        pulse_cyc[pulse_cnt]    = cyc;
        pulse_cnt++;
        @(negedge clk);
        @(negedge clk);
        resp_valid = 1'b1;
        if (ovr_i < ovr_n) begin
          resp_bit = ovr[ovr_i];
          ovr_i++;
        end else begin
          resp_bit = (int'(tap_o) >= edge_tap);
        end
        resp_cyc[resp_cnt] = cyc;
        resp_cnt++;
        @(negedge clk);
        resp_valid = 1'b0;
      end
    end
  end

  task automatic train(input int init, input int edg, output bit ok);
    int waitc;
    edge_tap = edg;
    pulse_cnt = 0;
    resp_cnt = 0;
    ovr_i = 0;
    @(negedge clk);
    tap_init_i = TAP_W'(init);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 pulse after start", int'(dqs_pulse_o), 1);
    chk("R2 tap seeded", int'(tap_o), init);
    chk("R9 done cleared by start", int'(done_o), 0);
    chk("R9 fail cleared by start", int'(fail_o), 0);
    waitc = 0;
    while (!done_o && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    ok = done_o;
    chk("training reached done", int'(done_o), 1);
  endtask

  task automatic t_reset;
    chk("R1 pulse at reset", int'(dqs_pulse_o), 0);
    chk("R1 done at reset", int'(done_o), 0);
    chk("R1 fail at reset", int'(fail_o), 0);
    chk("R1 tap at reset", int'(tap_o), 0);
  endtask

  task automatic t_from_below;
    bit ok;
    train(0, 5, ok);
    chk("R6 tap at edge", int'(tap_o), 5);
    chk("R6 no fail", int'(fail_o), 0);
    chk("R4 pulse count", pulse_cnt, 18);
    chk("R4 tap before step", tap_at_pulse[2], 0);
    chk("R4 increment after filtered 0", tap_at_pulse[3], 1);
    chk("R5 gap response to pulse", pulse_cyc[1] - resp_cyc[0], WAIT_CYC + 1);
    chk("R5 gap after step", pulse_cyc[4] - resp_cyc[3], WAIT_CYC + 1);
  endtask

  task automatic t_from_above;
    bit ok;
    train(10, 4, ok);
    chk("R4 decrement after filtered 1", tap_at_pulse[3], 9);
    chk("R6 tap after climb back", int'(tap_o), 4);
    chk("R6 no fail from above", int'(fail_o), 0);
    chk("R6 pulse count from above", pulse_cnt, 27);
  endtask

  task automatic t_filter;
    bit ok;
    ovr[0] = 1'b0; ovr[1] = 1'b1; ovr[2] = 1'b0; ovr[3] = 1'b0; ovr[4] = 1'b0;
    ovr_n = 5;
    train(0, 1, ok);
    ovr_n = 0;
    chk("R3 no step on broken run", tap_at_pulse[4], 0);
    chk("R3 step after full run", tap_at_pulse[5], 1);
    chk("R3 final tap", int'(tap_o), 1);
    chk("R3 pulse count", pulse_cnt, 8);
  endtask

  task automatic t_stray_and_hold;
    int pc;
    pc = pulse_cnt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      stray_valid = 1'b1;
      stray_bit = i[0];
    end
    @(negedge clk);
    stray_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 tap unchanged by stray valid", int'(tap_o), 1);
    chk("R8 no pulse from stray valid", pulse_cnt, pc);
    chk("R9 done held", int'(done_o), 1);
    chk("R9 fail held", int'(fail_o), 0);
  endtask

  task automatic t_fail_low;
    bit ok;
    train(0, 0, ok);
    chk("R7 fail at bottom", int'(fail_o), 1);
    chk("R7 tap kept at bottom", int'(tap_o), 0);
    chk("R7 pulses before bottom fail", pulse_cnt, 3);
    repeat (5) @(negedge clk);
    chk("R9 fail held after bottom fail", int'(fail_o), 1);
  endtask

  task automatic t_fail_high;
    bit ok;
    train(60, 100, ok);
    chk("R7 fail at top", int'(fail_o), 1);
    chk("R7 tap kept at top", int'(tap_o), 63);
    chk("R7 pulses before top fail", pulse_cnt, 12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_from_below();
    t_from_above();
    t_filter();
    t_stray_and_hold();
    t_fail_low();
    t_fail_high();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule